// File: doc/BRIEF.md
# Prioritized Interrupt Status and Mask Unit

This unit gathers level-sensitive interrupt requests from thirteen peripheral sources into a 32-bit status word. Alongside it sits a 32-bit mask word, and a priority encoder reduces the pending unmasked sources to a 3-bit processor priority level. Each source owns a fixed bit of the status word and belongs to one of three fixed groups: a low group asking for level 3, a middle group asking for level 5 and a high group asking for level 6.

Software reads and writes both words over a simple request/response register bus, with status at offset 0x7000 and mask at 0x7800. Two side inputs reach single status bits directly. A force control sets or clears the SCSI DMA bit, and a clear strobe drops the power bit.

The bus front end is a two-state machine. In `BUS_IDLE` it raises `bus_ready` and accepts a request. The transition `IDLE->RESP` is taken on an accepted request. In `BUS_RESP` it presents `bus_rvalid` with the read data for one cycle. The transition `RESP->IDLE` is always taken on the next clock. When `bus_valid` is low, the machine stays in `IDLE`.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Request input index i sets exactly one status bit, using this map (index:bit): 0:7 floppy, 1:3 keyboard, 2:2 power, 3:5 clock, 4:9 net receive, 5:10 net transmit, 6:12 SCSI, 7:17 serial, 8:21 serial DMA, 9:23 sound, 10:26 SCSI DMA, 11:27 net receive DMA, 12:28 net transmit DMA.
- R2: A 0-to-1 change of a request sets its status bit at the next clock edge. A 1-to-0 change clears it at the next edge.
- R3: Bits 2, 3, 5, 7, 9, 10 and 12 form the group at level 3. Bit 17 forms the group at level 5. Bits 21, 23, 26, 27 and 28 form the group at level 6. `ipl` only ever takes the values 0, 3, 5 or 6.
- R4: `ipl` is the highest group level among status bits that are set, unmasked and mapped to a source. It is 0 when no such bit exists. Status bits not mapped to a source never raise `ipl`.
- R5: A masked source (mask bit = 1) still shows as 1 in the status word. It adds nothing to `ipl`.
- R6: A write to offset 0x7000 replaces all 32 status bits. A read of 0x7000 returns the status word.
- R7: A write to offset 0x7800 replaces the mask word, and a read of 0x7800 returns it. After reset, status and mask are both 0, `ipl` is 0 and `bus_ready` is 1.
- R8: When `dma_force_we` is high, status bit 26 takes the value of `dma_force_val` at the next edge.
- R9: A pulse on `pwr_clr` clears status bit 2 at the next edge.
- R10: Within one cycle, precedence for a status bit runs from highest to lowest as follows:
  - a request edge;
  - the force control or the clear strobe;
  - a bus write.
- R11: A request is accepted only when `bus_ready` is 1. `bus_rvalid` is 1 in exactly the cycle after acceptance, and `bus_ready` is 0 in that cycle. A request presented while `bus_ready` is 0 is ignored. Read data is the register value before that request's own update. Other offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 13 | Level requests, indexed as in R1 |
| bus_valid | input | 1 | Register request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request can be accepted this cycle |
| bus_rvalid | output | 1 | Response cycle; read data valid |
| bus_rdata | output | 32 | Read data |
| dma_force_we | input | 1 | Force status bit 26 this cycle |
| dma_force_val | input | 1 | Value forced into bit 26 |
| pwr_clr | input | 1 | Clear strobe for status bit 2 |
| ipl | output | 3 | Encoded priority level |

## Verification
The bench aims at same-cycle collisions between a request edge, the force and clear side inputs, and a bus write to status. A design with the precedence reversed would lose a freshly raised interrupt. It also raises every source alone. A wrong entry in the bit map or group table would show up as a misplaced status bit or a wrong level. Masking every source while all are pending catches an encoder that ignores the mask, and also catches a design that hides masked bits from status. Requests sent during the response cycle must be dropped; a front end that accepts them would overwrite the mask.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int REG_W = 32;
    localparam int NSRC  = 13;

    localparam int SRC_FLOPPY  = 0;
    localparam int SRC_KBD     = 1;
    localparam int SRC_POWER   = 2;
    localparam int SRC_CLOCK   = 3;
    localparam int SRC_NET_RX  = 4;
    localparam int SRC_NET_TX  = 5;
    localparam int SRC_SCSI    = 6;
    localparam int SRC_SERIAL  = 7;
    localparam int SRC_SER_DMA = 8;
    localparam int SRC_SOUND   = 9;
    localparam int SRC_SC_DMA  = 10;
    localparam int SRC_RX_DMA  = 11;
    localparam int SRC_TX_DMA  = 12;

    typedef enum logic [1:0] {
        GRP_LOW  = 2'd0,
        GRP_MID  = 2'd1,
        GRP_HIGH = 2'd2
    } grp_e;

    localparam int NGRP = 3;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_st_e;

    // Status bit owned by each source index.
    function automatic int src_bit(input int idx);
        case (idx)
            SRC_FLOPPY:  return 7;
            SRC_KBD:     return 3;
            SRC_POWER:   return 2;
            SRC_CLOCK:   return 5;
            SRC_NET_RX:  return 9;
            SRC_NET_TX:  return 10;
            SRC_SCSI:    return 12;
            SRC_SERIAL:  return 17;
            SRC_SER_DMA: return 21;
            SRC_SOUND:   return 23;
            SRC_SC_DMA:  return 26;
            SRC_RX_DMA:  return 27;
            SRC_TX_DMA:  return 28;
            default:     return 0;
        endcase
    endfunction

    // Priority group of each source index.
    function automatic grp_e src_grp(input int idx);
        case (idx)
            SRC_SERIAL:                          return GRP_MID;
            SRC_SER_DMA, SRC_SOUND, SRC_SC_DMA,
            SRC_RX_DMA, SRC_TX_DMA:              return GRP_HIGH;
            default:                             return GRP_LOW;
        endcase
    endfunction

    function automatic logic [2:0] grp_level(input grp_e g);
        case (g)
            GRP_HIGH: return 3'd6;
            GRP_MID:  return 3'd5;
            default:  return 3'd3;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] grp_mask(input grp_e g);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (src_grp(i) == g) m[src_bit(i)] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [REG_W-1:0] ALL_SRC_MASK =
        grp_mask(GRP_LOW) | grp_mask(GRP_MID) | grp_mask(GRP_HIGH);

    localparam int FORCE_BIT = src_bit(SRC_SC_DMA);
    localparam int CLR_BIT   = src_bit(SRC_POWER);

endpackage

// File: rtl/irq_capture.sv
module irq_capture
    import irq_pkg::*;
#(
    parameter int DATA_W = REG_W,
    parameter int N_SRC  = NSRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_req,
    input  logic              sw_we,
    input  logic [DATA_W-1:0] sw_wdata,
    input  logic              force_we,
    input  logic              force_val,
    input  logic              clr_stb,
    output logic [DATA_W-1:0] status_o
);

    logic [N_SRC-1:0]  req_q;
    logic [N_SRC-1:0]  rise;
    logic [N_SRC-1:0]  fall;
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] status_d;

    assign rise = irq_req & ~req_q;
    assign fall = ~irq_req & req_q;

    // Lowest precedence first; later assignments win.
    always_comb begin
        status_d = status_q;
        if (sw_we)    status_d = sw_wdata;
        if (force_we) status_d[FORCE_BIT] = force_val;
        if (clr_stb)  status_d[CLR_BIT] = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (rise[i])      status_d[src_bit(i)] = 1'b1;
            else if (fall[i]) status_d[src_bit(i)] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            req_q    <= '0;
        end else begin
            status_q <= status_d;
            req_q    <= irq_req;
        end
    end

    assign status_o = status_q;

    generate
        for (genvar s = 0; s < N_SRC; s++) begin : g_src_chk
            localparam int B = src_bit(s);
            AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n) rise[s] |=> status_o[B]); // R2
            AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) fall[s] |=> !status_o[B]); // R2
        end
    endgenerate

    AST_CLR_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (clr_stb && !rise[SRC_POWER]) |=> !status_o[CLR_BIT]); // R9
    AST_FORCE_BIT: assert property (@(posedge clk) disable iff (!rst_n) (force_we && !rise[SRC_SC_DMA] && !fall[SRC_SC_DMA]) |=> (status_o[FORCE_BIT] == $past(force_val))); // R8
    AST_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (sw_we && !force_we && !clr_stb && rise == '0 && fall == '0) |=> (status_o == $past(sw_wdata))); // R6

endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
    import irq_pkg::*;
#(
    parameter int DATA_W = REG_W,
    parameter int LVL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [LVL_W-1:0]  level_o
);

    logic [DATA_W-1:0] pend;
    logic [NGRP-1:0]   grp_hit;

    assign pend = status_i & ~mask_i;

    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            localparam logic [DATA_W-1:0] GMASK = grp_mask(grp_e'(g));
            assign grp_hit[g] = |(pend & GMASK);
        end
    endgenerate

    // Highest group index wins.
    always_comb begin
        level_o = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (grp_hit[g]) level_o = LVL_W'(grp_level(grp_e'(g)));
        end
    end

    AST_LEVEL_TOP: assert property (@(posedge clk) disable iff (!rst_n) (|(status_i & ~mask_i & grp_mask(GRP_HIGH))) |-> (level_o == 3'd6)); // R4
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) ((status_i & ~mask_i & ALL_SRC_MASK) == '0) |-> (level_o == '0)); // R5
    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (level_o == 3'd0 || level_o == 3'd3 || level_o == 3'd5 || level_o == 3'd6)); // R3

endmodule

// File: rtl/irq_regbus.sv
module irq_regbus
    import irq_pkg::*;
#(
    parameter int DATA_W = REG_W,
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] STAT_OFF = 16'h7000,
    parameter logic [ADDR_W-1:0] MASK_OFF = 16'h7800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [DATA_W-1:0] status_i,
    output logic [DATA_W-1:0] mask_o,
    output logic              stat_we,
    output logic [DATA_W-1:0] stat_wdata
);

    bus_st_e           state_q;
    bus_st_e           state_d;
    logic              accept;
    logic              hit_stat;
    logic              hit_mask;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] mask_q;

    assign hit_stat = (req_addr == STAT_OFF);
    assign hit_mask = (req_addr == MASK_OFF);

    // Next-state process.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (req_valid) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // Output process.
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            BUS_IDLE: req_ready = 1'b1;
            BUS_RESP: rsp_valid = 1'b1;
            default:  req_ready = 1'b0;
        endcase
    end

    assign accept = req_valid && (state_q == BUS_IDLE);

    always_comb begin
        rd_mux = '0;
        if (hit_stat)      rd_mux = status_i;
        else if (hit_mask) rd_mux = mask_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            rdata_q <= '0;
        end else if (accept) begin
            rdata_q <= req_write ? '0 : rd_mux;
            if (req_write && hit_mask) mask_q <= req_wdata;
        end
    end

    assign rsp_rdata  = rdata_q;
    assign mask_o     = mask_q;
    assign stat_we    = accept && req_write && hit_stat;
    assign stat_wdata = req_wdata;

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> rsp_valid); // R11
    AST_NO_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> !req_ready); // R11
    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready && req_write && req_addr == MASK_OFF) |=> (mask_o == $past(req_wdata))); // R7

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int DATA_W = REG_W,
    parameter int ADDR_W = 16,
    parameter int N_SRC  = NSRC,
    parameter int LVL_W  = 3,
    parameter logic [ADDR_W-1:0] STAT_OFF = 16'h7000,
    parameter logic [ADDR_W-1:0] MASK_OFF = 16'h7800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_req,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dma_force_we,
    input  logic              dma_force_val,
    input  logic              pwr_clr,
    output logic [LVL_W-1:0]  ipl
);

    logic [DATA_W-1:0] status_w;
    logic [DATA_W-1:0] mask_w;
    logic              stat_we_w;
    logic [DATA_W-1:0] stat_wdata_w;

    irq_regbus #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .STAT_OFF (STAT_OFF),
        .MASK_OFF (MASK_OFF)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (bus_valid),
        .req_write  (bus_write),
        .req_addr   (bus_addr),
        .req_wdata  (bus_wdata),
        .req_ready  (bus_ready),
        .rsp_valid  (bus_rvalid),
        .rsp_rdata  (bus_rdata),
        .status_i   (status_w),
        .mask_o     (mask_w),
        .stat_we    (stat_we_w),
        .stat_wdata (stat_wdata_w)
    );

    irq_capture #(
        .DATA_W (DATA_W),
        .N_SRC  (N_SRC)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .sw_we     (stat_we_w),
        .sw_wdata  (stat_wdata_w),
        .force_we  (dma_force_we),
        .force_val (dma_force_val),
        .clr_stb   (pwr_clr),
        .status_o  (status_w)
    );

    irq_level_enc #(
        .DATA_W (DATA_W),
        .LVL_W  (LVL_W)
    ) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_w),
        .mask_i   (mask_w),
        .level_o  (ipl)
    );

endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;

    localparam int NS = 13;
    localparam logic [15:0] A_STAT = 16'h7000;
    localparam logic [15:0] A_MASK = 16'h7800;
    localparam logic [15:0] A_NONE = 16'h7004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NS-1:0] irq_req = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic        dma_force_we = 1'b0;
    logic        dma_force_val = 1'b0;
    logic        pwr_clr = 1'b0;
    logic [2:0]  ipl;

    always #2 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .dma_force_we(dma_force_we),
        .dma_force_val(dma_force_val), .pwr_clr(pwr_clr), .ipl(ipl)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int sb [NS] = '{7, 3, 2, 5, 9, 10, 12, 17, 21, 23, 26, 27, 28};
    localparam logic [31:0] M_LOW  = 32'h0000_16AC;
    localparam logic [31:0] M_MID  = 32'h0002_0000;
    localparam logic [31:0] M_HIGH = 32'h1CA0_0000;

    logic [31:0]   m_stat = '0;
    logic [31:0]   m_mask = '0;
    logic [NS-1:0] m_prev = '0;
    bit            m_busy = 1'b0;
    logic [NS-1:0] cur_rq = '0;
    string         rd_tag = "";
    string         lv_tag = "R4";

    function automatic logic [2:0] exp_level(input logic [31:0] s, input logic [31:0] m);
        logic [31:0] p;
        p = s & ~m;
        if (|(p & M_HIGH)) return 3'd6;
        if (|(p & M_MID))  return 3'd5;
        if (|(p & M_LOW))  return 3'd3;
        return 3'd0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(input logic [NS-1:0] rq, input bit bv, input bit wr,
                        input logic [15:0] ad, input logic [31:0] wd,
                        input bit fwe, input bit fv, input bit clr);
        logic [31:0] ns;
        logic [31:0] nm;
        logic [31:0] exp_rd;
        bit acc;
        string t;
        @(negedge clk);
        irq_req = rq; bus_valid = bv; bus_write = wr; bus_addr = ad;
        bus_wdata = wd; dma_force_we = fwe; dma_force_val = fv; pwr_clr = clr;
        acc = bv && !m_busy;
        exp_rd = '0;
        if (acc && !wr) exp_rd = (ad == A_STAT) ? m_stat : (ad == A_MASK) ? m_mask : 32'h0;
        ns = m_stat; nm = m_mask;
        if (acc && wr && ad == A_STAT) ns = wd;
        if (acc && wr && ad == A_MASK) nm = wd;
        if (fwe) ns[26] = fv;
        if (clr) ns[2] = 1'b0;
        for (int i = 0; i < NS; i++) begin
            if (rq[i] && !m_prev[i]) ns[sb[i]] = 1'b1;
            else if (!rq[i] && m_prev[i]) ns[sb[i]] = 1'b0;
        end
        @(posedge clk);
        #1;
        m_stat = ns; m_mask = nm; m_prev = rq; m_busy = acc;
        chk("R11 rvalid", 32'(bus_rvalid), 32'(acc));
        chk("R11 ready", 32'(bus_ready), 32'(!acc));
        if (acc && !wr) begin
            if (rd_tag != "") t = rd_tag;
            else t = (ad == A_STAT) ? "R6" : (ad == A_MASK) ? "R7" : "R11";
            chk({t, " rdata"}, bus_rdata, exp_rd);
        end
        chk({lv_tag, " ipl"}, 32'(ipl), 32'(exp_level(m_stat, m_mask)));
    endtask

    task automatic idle();
        step(cur_rq, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic rd(input logic [15:0] ad);
        step(cur_rq, 1'b1, 1'b0, ad, '0, 1'b0, 1'b0, 1'b0);
        idle();
    endtask

    task automatic wrr(input logic [15:0] ad, input logic [31:0] d);
        step(cur_rq, 1'b1, 1'b1, ad, d, 1'b0, 1'b0, 1'b0);
        idle();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R11: watchdog expired, got hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R7: reset state
        chk("R7 reset ipl", 32'(ipl), 32'h0);
        chk("R7 reset ready", 32'(bus_ready), 32'h1);
        rd_tag = "R7"; rd(A_STAT); rd(A_MASK);

        // R1 / R3 / R2: each source alone
        for (int i = 0; i < NS; i++) begin
            cur_rq = NS'(1) << i;
            lv_tag = "R3"; idle();
            rd_tag = "R1"; rd(A_STAT);
            chk("R1 map", m_stat, 32'h1 << sb[i]);
            cur_rq = '0;
            lv_tag = "R2"; idle();
            rd_tag = "R2"; rd(A_STAT);
        end

        // R5: all masked, all pending
        lv_tag = "R5"; rd_tag = "R5";
        wrr(A_MASK, 32'hFFFF_FFFF);
        cur_rq = '1; idle();
        chk("R5 ipl masked", 32'(ipl), 32'h0);
        rd(A_STAT);
        chk("R5 status shows", m_stat, M_LOW | M_MID | M_HIGH);
        wrr(A_MASK, 32'h0000_0000);
        chk("R5 unmask ipl", 32'(ipl), 32'h6);
        cur_rq = '0; idle();

        // R4: mixing groups, unmapped bits
        lv_tag = "R4"; rd_tag = "R4";
        cur_rq = NS'(1) << 2; idle();
        chk("R4 low only", 32'(ipl), 32'h3);
        cur_rq = cur_rq | (NS'(1) << 7); idle();
        chk("R4 mid wins", 32'(ipl), 32'h5);
        cur_rq = cur_rq | (NS'(1) << 9); idle();
        chk("R4 high wins", 32'(ipl), 32'h6);
        cur_rq = '0; idle();
        wrr(A_STAT, 32'hE001_0003);
        chk("R4 unmapped bits", 32'(ipl), 32'h0);
        rd_tag = "R6"; rd(A_STAT);
        chk("R6 full write", m_stat, 32'hE001_0003);

        // R8: force bit 26
        rd_tag = "R8"; lv_tag = "R8";
        step(cur_rq, 1'b0, 1'b0, '0, '0, 1'b1, 1'b1, 1'b0);
        chk("R8 force set ipl", 32'(ipl), 32'h6);
        rd(A_STAT);
        step(cur_rq, 1'b0, 1'b0, '0, '0, 1'b1, 1'b0, 1'b0);
        rd(A_STAT);
        chk("R8 force clear", 32'(m_stat[26]), 32'h0);

        // R9: clear strobe while request stays high
        rd_tag = "R9"; lv_tag = "R9";
        cur_rq = NS'(1) << 2; idle();
        step(cur_rq, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
        chk("R9 strobe ipl", 32'(ipl), 32'h0);
        rd(A_STAT);
        cur_rq = '0; idle();

        // R10: same-cycle collisions
        rd_tag = "R10"; lv_tag = "R10";
        wrr(A_STAT, 32'h0);
        cur_rq = NS'(1) << 2;
        step(cur_rq, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
        chk("R10 rise over clr", 32'(ipl), 32'h3);
        cur_rq = cur_rq | (NS'(1) << 10);
        step(cur_rq, 1'b0, 1'b0, '0, '0, 1'b1, 1'b0, 1'b0);
        chk("R10 rise over force", 32'(ipl), 32'h6);
        cur_rq = cur_rq | (NS'(1) << 9);
        step(cur_rq, 1'b1, 1'b1, A_STAT, 32'h0, 1'b0, 1'b0, 1'b0);
        idle();
        rd(A_STAT);
        chk("R10 rise over bus", m_stat, 32'h0080_0000);
        step(cur_rq, 1'b1, 1'b1, A_STAT, 32'h0000_0004, 1'b1, 1'b1, 1'b0);
        idle(); rd(A_STAT);
        chk("R10 force over bus", m_stat, 32'h0400_0004);
        cur_rq = '0; idle();

        // R11: unmapped, busy-dropped request
        rd_tag = "R11"; lv_tag = "R4";
        wrr(A_NONE, 32'hFFFF_FFFF);
        rd(A_NONE);
        wrr(A_MASK, 32'h0000_FFFF);
        step(cur_rq, 1'b1, 1'b1, A_MASK, 32'h1234_0000, 1'b0, 1'b0, 1'b0);
        step(cur_rq, 1'b1, 1'b1, A_MASK, 32'h0000_0001, 1'b0, 1'b0, 1'b0);
        idle(); rd(A_MASK);
        chk("R11 busy ignored", m_mask, 32'h1234_0000);

        // Random mix
        rd_tag = ""; lv_tag = "R4";
        for (int n = 0; n < 4000; n++) begin
            logic [NS-1:0] flip;
            logic [15:0] a;
            for (int b = 0; b < NS; b++) flip[b] = ($urandom % 8) == 0;
            cur_rq = cur_rq ^ flip;
            case ($urandom % 4)
                0, 2:    a = A_STAT;
                1:       a = A_MASK;
                default: a = A_NONE;
            endcase
            step(cur_rq, ($urandom % 3) == 0, ($urandom % 2) == 1, a, $urandom,
                 ($urandom % 10) == 0, ($urandom % 2) == 1, ($urandom % 10) == 0);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule